// File: doc/BRIEF.md
# Phase-Offset Quarter-Wave Sine Lookup

This block sits after a phase accumulator in a digitally synthesized carrier path. Each cycle it adds an 8-bit phase offset to the 8-bit accumulator phase and registers the wrapped sum as the modulated phase. The following cycle it turns that phase into an 8-bit signed sine amplitude. The two top phase bits pick the quadrant. The bit below the sign bit mirrors the table address, and the top bit sets the sign of the result. Only one quarter of a period is stored, as 64 unsigned 7-bit magnitudes.

One offset step is 2π/256 radians. Binary phase-shift keying is done by driving the offset with 128 (half a turn) for one data value and 0 for the other. The output then inverts and the carrier frequency stays the same. Two single-bit square waves come out of the same modulated phase. One follows the sign of the sine and one follows the sign of the cosine, so they shift with the offset exactly as the amplitude does.

Top module: `phase_offset_sine`

## Requirements
- R1: One clock edge after the inputs are sampled, `mod_phase_o` equals `(phase_i + offset_i) mod 256`.
- R2: The amplitude for a phase/offset pair appears on `amp_o` exactly two clock edges after the pair is sampled, and a new pair is accepted on every cycle.
- R3: Across the first quadrant (modulated phase 0..63), the amplitude never decreases, and at phase 63 it reaches the peak value 127.
- R4: When phase bit 6 is set, the table address is the bitwise complement of phase bits 5..0. Therefore amp(p) equals amp(127-p) and amp(128+p) equals amp(255-p) for p in 0..63.
- R5: `amp_o` is two's complement, and its bit 7 equals bit 7 of the modulated phase it was computed from.
- R6: For the negative half-period, the word is the bitwise complement of the positive one: amp(p+128) equals ~amp(p).
- R7: For every modulated phase p, the signed amplitude is within 1 LSB of 127·sin(2π(p+0.5)/256) − 0.5.
- R8: An offset of 128 yields the bitwise complement of the amplitude produced with offset 0 at the same accumulator phase (a 180° carrier flip).
- R9: In the same cycle as `amp_o`, `sq_sin_o` equals bit 7 of the modulated phase, and `sq_cos_o` equals bit 7 XOR bit 6 of it.
- R10: While `rst_n` is low, `mod_phase_o`, `amp_o`, `sq_sin_o` and `sq_cos_o` are all 0.
- R11: One offset LSB is one phase step of 2π/256: amp(phase p, offset o) equals amp(phase (p+o) mod 256, offset 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_i | input | 8 | Accumulator phase, 2π/256 per LSB |
| offset_i | input | 8 | Phase offset, 2π/256 per LSB (128 = 180°) |
| mod_phase_o | output | 8 | Registered modulated phase |
| amp_o | output | 8 | Two's complement sine amplitude |
| sq_sin_o | output | 1 | Sine-sign square wave of the modulated phase |
| sq_cos_o | output | 1 | Cosine-sign square wave of the modulated phase |

## Verification
On every cycle, the assertions check three things: the registered sum, the alignment of the amplitude sign bit and both square waves with the modulated phase one stage earlier, and the two-cycle path from the input pair to the sign of the amplitude. Some properties only show up when whole phase sweeps are compared with each other: the accuracy of the folded table against a real sine, the quadrant mirror and half-period complement symmetry, monotonic rise to the peak, and the equivalence between offset and phase (including the 180° BPSK flip). The bench covers these, together with back-to-back streaming that confirms a new amplitude arrives every cycle.

// File: rtl/pos_pkg.sv
package pos_pkg;

    // Fixed-point scale used only while building the quarter table.
    localparam int     FX_BITS = 24;
    // pi scaled by 2^FX_BITS, rounded.
    localparam longint PI_FX   = 64'sd52707179;

    // Magnitude of one table entry: peak * sin((2*idx+1) * pi / 2^ph_w),
    // rounded to nearest, from a truncated odd power series.
    function automatic int quarter_sine(int idx, int ph_w, int peak);
        longint ang;
        longint ang_sq;
        longint term;
        longint acc;
        longint res;
        ang    = ((2 * longint'(idx) + 1) * PI_FX) >>> ph_w;
        ang_sq = (ang * ang) >>> FX_BITS;
        term   = ang;
        acc    = ang;
        for (int k = 1; k <= 5; k++) begin
            term = -(((term * ang_sq) >>> FX_BITS) / longint'((2 * k) * (2 * k + 1)));
            acc  = acc + term;
        end
        res = (acc * longint'(peak) + (longint'(1) <<< (FX_BITS - 1))) >>> FX_BITS;
        if (res > longint'(peak)) res = longint'(peak);
        if (res < 0) res = 0;
        return int'(res);
    endfunction

endpackage

// File: rtl/pos_phase_mod.sv
module pos_phase_mod #(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase_i,
    input  logic [PH_W-1:0] offset_i,
    output logic [PH_W-1:0] mod_phase_o
);

    typedef struct packed {
        logic [PH_W-1:0] mod_phase;
    } mod_state_t;

    mod_state_t st_d, st_q;

    // Modulo-2^PH_W sum: the carry out is dropped, which wraps the angle.
    always_comb begin
        st_d           = st_q;
        st_d.mod_phase = phase_i + offset_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mod_phase_o = st_q.mod_phase;

    AST_MODPH_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mod_phase_o == $past(PH_W'(phase_i + offset_i)))); // R1

endmodule

// File: rtl/pos_quarter_rom.sv
module pos_quarter_rom #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PEAK  = (1 << DATA_W) - 1;
    localparam int PH_W  = ADDR_W + 2;

    logic [DATA_W-1:0] table_w [DEPTH];

    // Entries are sampled at half-step centres so the mirrored quadrant
    // lines up exactly under address complement.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int VAL = pos_pkg::quarter_sine(g, PH_W, PEAK);
        assign table_w[g] = DATA_W'(VAL);
    end

    assign data_o = table_w[addr_i];

endmodule

// File: rtl/pos_amp_stage.sv
module pos_amp_stage #(
    parameter int PH_W  = 8,
    parameter int AMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  mod_phase_i,
    output logic [AMP_W-1:0] amp_o,
    output logic             sq_sin_o,
    output logic             sq_cos_o
);

    localparam int ADDR_W = PH_W - 2;
    localparam int MAG_W  = AMP_W - 1;

    typedef struct packed {
        logic [AMP_W-1:0] amp;
        logic             sq_sin;
        logic             sq_cos;
    } amp_state_t;

    amp_state_t st_d, st_q;

    logic              neg_half_w;
    logic              mirror_w;
    logic [ADDR_W-1:0] addr_w;
    logic [MAG_W-1:0]  mag_w;

    assign neg_half_w = mod_phase_i[PH_W-1];
    assign mirror_w   = mod_phase_i[PH_W-2];
    // Falling quadrants walk the table backwards.
    assign addr_w     = mirror_w ? ~mod_phase_i[ADDR_W-1:0] : mod_phase_i[ADDR_W-1:0];

    pos_quarter_rom #(
        .ADDR_W (ADDR_W),
        .DATA_W (MAG_W)
    ) u_rom (
        .addr_i (addr_w),
        .data_o (mag_w)
    );

    // Negative half: one's complement of the magnitude, i.e. -(mag+1).
    // The sign bit therefore copies the phase MSB with no adder.
    always_comb begin
        st_d        = st_q;
        st_d.amp    = neg_half_w ? ~{1'b0, mag_w} : {1'b0, mag_w};
        st_d.sq_sin = neg_half_w;
        st_d.sq_cos = neg_half_w ^ mirror_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign amp_o    = st_q.amp;
    assign sq_sin_o = st_q.sq_sin;
    assign sq_cos_o = st_q.sq_cos;

    AST_AMP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (amp_o[AMP_W-1] == $past(mod_phase_i[PH_W-1]))); // R5

    AST_SQ_SIN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sq_sin_o == $past(mod_phase_i[PH_W-1]))); // R9

    AST_SQ_COS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sq_cos_o == $past(mod_phase_i[PH_W-1] ^ mod_phase_i[PH_W-2]))); // R9

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(mod_phase_i)) |=> $stable(amp_o)); // R2

endmodule

// File: rtl/phase_offset_sine.sv
module phase_offset_sine #(
    parameter int PH_W  = 8,
    parameter int AMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  phase_i,
    input  logic [PH_W-1:0]  offset_i,
    output logic [PH_W-1:0]  mod_phase_o,
    output logic [AMP_W-1:0] amp_o,
    output logic             sq_sin_o,
    output logic             sq_cos_o
);

    logic [PH_W-1:0] mod_phase_w;

    pos_phase_mod #(
        .PH_W (PH_W)
    ) u_mod (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase_i),
        .offset_i    (offset_i),
        .mod_phase_o (mod_phase_w)
    );

    pos_amp_stage #(
        .PH_W  (PH_W),
        .AMP_W (AMP_W)
    ) u_amp (
        .clk         (clk),
        .rst_n       (rst_n),
        .mod_phase_i (mod_phase_w),
        .amp_o       (amp_o),
        .sq_sin_o    (sq_sin_o),
        .sq_cos_o    (sq_cos_o)
    );

    assign mod_phase_o = mod_phase_w;

    logic [PH_W-1:0] in_sum_w;
    assign in_sum_w = phase_i + offset_i;

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (amp_o[AMP_W-1] == $past(in_sum_w[PH_W-1], 2))); // R2

endmodule

// File: tb/sim_phase_offset_sine.sv
module sim_phase_offset_sine;

    localparam int CLK_PERIOD = 10;
    localparam int N_STREAM   = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] phase_i = '0;
    logic [7:0] offset_i = '0;
    logic [7:0] mod_phase_o;
    logic [7:0] amp_o;
    logic       sq_sin_o;
    logic       sq_cos_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int amp_tab [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_offset_sine u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase_i),
        .offset_i    (offset_i),
        .mod_phase_o (mod_phase_o),
        .amp_o       (amp_o),
        .sq_sin_o    (sq_sin_o),
        .sq_cos_o    (sq_cos_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic real ref_amp(int p);
        return 127.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 256.0) - 0.5;
    endfunction

    function automatic int signed_amp(logic [7:0] a);
        return int'($signed(a));
    endfunction

    // Apply one pair, hold it, and return the settled amplitude word.
    task automatic apply(input int p, input int o, output int amp_word);
        @(negedge clk);
        phase_i  = 8'(p);
        offset_i = 8'(o);
        @(posedge clk); #1;
        check("R1 mod phase", int'(mod_phase_o), (p + o) % 256);
        @(posedge clk); #1;
        amp_word = int'(amp_o);
    endtask

    initial begin
        int w;
        int w2;
        real diff;
        int mp;
        int ph_hist [N_STREAM];
        int of_hist [N_STREAM];

        void'($urandom(32'h1f2e3d4c));
        phase_i  = 8'd77;
        offset_i = 8'd200;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset holds every output at zero
        check("R10 mod phase in reset", int'(mod_phase_o), 0);
        check("R10 amp in reset", int'(amp_o), 0);
        check("R10 sq_sin in reset", int'(sq_sin_o), 0);
        check("R10 sq_cos in reset", int'(sq_cos_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Full sweep at zero offset: R7 accuracy, R5 sign, R9 squares
        for (int p = 0; p < 256; p++) begin
            apply(p, 0, w);
            amp_tab[p] = w;
            diff = real'(signed_amp(8'(w))) - ref_amp(p);
            checks++;
            if (diff > 1.0001 || diff < -1.0001) begin
                errors++;
                $display("FAIL R7 accuracy at phase %0d: actual %0d expected %f",
                         p, signed_amp(8'(w)), ref_amp(p));
            end
            check("R5 sign bit", (w >> 7) & 1, (p >> 7) & 1);
            check("R9 sq_sin", int'(sq_sin_o), (p >> 7) & 1);
            check("R9 sq_cos", int'(sq_cos_o), ((p >> 7) ^ (p >> 6)) & 1);
        end

        // R3: first quadrant rises to the peak
        for (int p = 1; p < 64; p++) begin
            check("R3 monotonic", int'(amp_tab[p] >= amp_tab[p-1]), 1);
        end
        check("R3 peak", amp_tab[63], 127);

        // R4 mirror and R6 complement
        for (int p = 0; p < 64; p++) begin
            check("R4 mirror upper quadrant", amp_tab[p], amp_tab[127 - p]);
            check("R4 mirror lower quadrant", amp_tab[128 + p], amp_tab[255 - p]);
        end
        for (int p = 0; p < 128; p++) begin
            check("R6 negative half", amp_tab[p + 128], (~amp_tab[p]) & 8'hFF);
        end

        // R8 BPSK flip, directed corners then random phases
        apply(0, 128, w);   check("R8 flip at 0", w, (~amp_tab[0]) & 8'hFF);
        apply(255, 128, w); check("R8 flip at 255", w, (~amp_tab[255]) & 8'hFF);
        apply(63, 128, w);  check("R8 flip at peak", w, (~amp_tab[63]) & 8'hFF);
        for (int i = 0; i < 20; i++) begin
            mp = int'($urandom_range(255));
            apply(mp, 128, w);
            apply(mp, 0, w2);
            check("R8 BPSK complement", w, (~w2) & 8'hFF);
        end

        // R11 offset equals phase step, incl. wrap-around
        apply(200, 100, w); check("R11 wrap", w, amp_tab[44]);
        apply(255, 1, w);   check("R11 wrap to zero", w, amp_tab[0]);
        for (int i = 0; i < 30; i++) begin
            int p;
            int o;
            p = int'($urandom_range(255));
            o = int'($urandom_range(255));
            apply(p, o, w);
            check("R11 offset step", w, amp_tab[(p + o) % 256]);
        end

        // R2 streaming: new pair each cycle, amplitude two edges later
        for (int i = 0; i < N_STREAM; i++) begin
            @(negedge clk);
            ph_hist[i] = int'($urandom_range(255));
            of_hist[i] = (i % 7 == 0) ? 128 : int'($urandom_range(255));
            phase_i  = 8'(ph_hist[i]);
            offset_i = 8'(of_hist[i]);
            @(posedge clk); #1;
            check("R1 streaming mod phase", int'(mod_phase_o), (ph_hist[i] + of_hist[i]) % 256);
            if (i >= 1) begin
                check("R2 latency", int'(amp_o), amp_tab[(ph_hist[i-1] + of_hist[i-1]) % 256]);
            end
        end

        // R10 again: asynchronous reset mid-stream
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 async reset amp", int'(amp_o), 0);
        check("R10 async reset mod phase", int'(mod_phase_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule